// File: doc/BRIEF.md
# Multi-Mode Attribute Colour Decoder

This block turns the per-pixel data of a display pipeline into an 8-bit logical colour number, ready for a later palette stage. For every pixel it receives the pixel bit, the attribute byte that covers it, the flash phase, four bitplane bits and the current border colour. One of five decode methods is applied, and the result leaves on a registered output one clock later.

The decode method is held in one of sixteen 4-bit control registers. These registers are loaded by writes to I/O port 0x8E3B. The upper nibble of the written byte picks the register and the lower nibble is the value. All sixteen registers are driven out of the block so that neighbouring video logic can use the registers it owns. Register 3 selects the attribute decode method.

In the attribute byte, bits 2:0 are the ink colour and bits 5:3 are the paper colour. Bit 6 and bit 7 have a meaning that depends on the method.

Top module: `attr_colour_decoder`

## Requirements
- R1: After a clock edge with `rst_n` low, all sixteen control registers are zero, `colour` is 0 and the method is the standard decode (code 0000).
- R2: A write (`io_wr` high) with `io_addr` equal to 0x8E3B loads `io_data[3:0]` into register `io_data[7:4]`. The new value appears on `ctrl_regs[4*i+3:4*i]` after that edge. Register 3 holds the decode method.
- R3: A write to any other address, or a cycle with `io_wr` low, changes no register. A write to a register other than 3 leaves the decode method unchanged.
- R4: Method 0000 (standard): the colour is ink (attr[2:0]) when the pixel bit is 1 and paper (attr[5:3]) when it is 0. The output is {4'b0, attr[6], colour}.
- R5: In method 0000, when attr[7] and `flash_phase` are both 1, the pixel bit is inverted before ink or paper is chosen.
- R6: Method 0001 (16+16): ink pixels give {4'b0, attr[6], ink} and paper pixels give {4'b0, attr[7], paper}. Flash does not apply.
- R7: Method 0010 (32-colour): the output is {3'b0, attr[7], attr[6], ink or paper}, so every value lies in 0..31.
- R8: Method 0100 (256-colour): ink pixels output the whole attribute byte, and paper pixels output `border`.
- R9: Method 0110 (planar): the output is {4'b0, planes[3:0]}, with plane 0 as the LSB. The attribute, the pixel bit and flash have no effect.
- R10: Every other method code (0011, 0101, 0111, 1xxx) decodes exactly as method 0000, including flash.
- R11: `colour` is registered. It reflects the inputs and the method present at the previous rising edge and holds steady between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O port address |
| io_data | input | 8 | I/O write data: register index in bits 7:4, value in bits 3:0 |
| pix_bit | input | 1 | Pixel bit (1 = ink) |
| attr | input | 8 | Attribute byte for the pixel |
| flash_phase | input | 1 | Flash phase, 1 = inverted phase |
| planes | input | 4 | One bit from each of four bitplanes |
| border | input | 8 | Current border logical colour |
| colour | output | 8 | Logical colour number, one cycle latency |
| ctrl_regs | output | 64 | All sixteen control registers, register i in bits 4*i+3:4*i |

## Verification
Random attribute bytes, pixel bits, flash phases, plane bits and border colours are applied under every method code, including reserved ones. This separates the ink and paper paths and shows which attribute bit feeds each bright position. Directed cases set attr[7] with the flash phase both high and low. These show that only the standard decode, and the reserved codes that fall back to it, apply the swap. Random control writes mix the matching port with other addresses and other register indices, so a wrong address match or a wrong index decode shows up as a changed method or a wrong register nibble. A mid-cycle input change checks that the output is held between edges.

// File: rtl/attr_dec_pkg.sv
// Package: shared constants and method codes for the attribute colour decoder.
// Assumes 4-bit method codes held in a control register.
package attr_dec_pkg;
    localparam int REG_W = 4;

    typedef enum logic [3:0] {
        M_STD     = 4'b0000,
        M_SPLIT   = 4'b0001,
        M_BRIGHT4 = 4'b0010,
        M_FULL8   = 4'b0100,
        M_PLANAR  = 4'b0110
    } method_e;
endpackage

// File: rtl/ctrl_regfile.sv
// Control register file: decodes writes to one I/O port into sixteen 4-bit
// registers. The high data nibble is the index and the low nibble the value.
// Assumes the write strobe is a single-cycle, synchronous pulse.
module ctrl_regfile #(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] PORT_ADR = 16'h8E3B,
    parameter int          IDX_W    = 4,
    parameter int          VAL_W    = 4,
    parameter int          SEL_IDX  = 3,
    localparam int         NREG     = 1 << IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [IDX_W+VAL_W-1:0] data,
    output logic [NREG*VAL_W-1:0]  regs_flat,
    output logic [VAL_W-1:0]       sel_val
);
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [VAL_W-1:0] val;

    // Port match and field split of the written byte.
    always_comb begin
        hit = wr && (addr == PORT_ADR[ADDR_W-1:0]);
        idx = data[IDX_W+VAL_W-1:VAL_W];
        val = data[VAL_W-1:0];
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [VAL_W-1:0] q;
        // Register i: cleared on reset, loaded when the index matches.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (hit && idx == IDX_W'(i))
                q <= val;
        end
        assign regs_flat[i*VAL_W +: VAL_W] = q;
    end

    assign sel_val = regs_flat[SEL_IDX*VAL_W +: VAL_W];

    // R2: a matching write to the method register loads its value.
    a_r2_method_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == PORT_ADR[ADDR_W-1:0] && data[IDX_W+VAL_W-1:VAL_W] == IDX_W'(SEL_IDX))
        |=> sel_val == $past(data[VAL_W-1:0]));

    // R3: without a matching write the method register is unchanged.
    a_r3_method_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == PORT_ADR[ADDR_W-1:0]) |=> $stable(sel_val));

    // R1: reset clears every register.
    a_r1_regs_clear: assert property (@(posedge clk)
        !rst_n |=> regs_flat == '0);
endmodule

// File: rtl/attr_decode_core.sv
// Combinational decode of one pixel into a logical colour number under the
// selected method. Assumes ink in attr[2:0] and paper in attr[5:3]. Unknown
// method codes fall back to the standard decode.
module attr_decode_core
    import attr_dec_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int CLR_W = 3,
    parameter int NPL   = 4
) (
    input  logic [REG_W-1:0] method,
    input  logic             pix_bit,
    input  logic [7:0]       attr,
    input  logic             flash_phase,
    input  logic [NPL-1:0]   planes,
    input  logic [COL_W-1:0] border,
    output logic [COL_W-1:0] colour
);
    logic [CLR_W-1:0] ink, paper;
    logic             b_lo, b_hi;
    logic             std_sel;

    // Field split of the attribute byte.
    always_comb begin
        ink     = attr[CLR_W-1:0];
        paper   = attr[2*CLR_W-1:CLR_W];
        b_lo    = attr[6];
        b_hi    = attr[7];
        std_sel = pix_bit ^ (b_hi & flash_phase);
    end

    // Method multiplexer producing the logical colour.
    always_comb begin
        case (method)
            M_SPLIT:
                colour = pix_bit ? COL_W'({b_lo, ink}) : COL_W'({b_hi, paper});
            M_BRIGHT4:
                colour = COL_W'({b_hi, b_lo, (pix_bit ? ink : paper)});
            M_FULL8:
                colour = pix_bit ? COL_W'(attr) : border;
            M_PLANAR:
                colour = COL_W'(planes);
            default:
                colour = COL_W'({b_lo, (std_sel ? ink : paper)});
        endcase
    end
endmodule

// File: rtl/attr_colour_decoder.sv
// Top level: control register file plus per-pixel attribute decode with a
// registered colour output (one cycle latency). Assumes synchronous
// active-low reset and pixel inputs valid at every rising edge.
module attr_colour_decoder
    import attr_dec_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] PORT_ADR = 16'h8E3B,
    parameter int          COL_W    = 8,
    parameter int          NPL      = 4,
    parameter int          SEL_IDX  = 3,
    localparam int         NREG     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    io_wr,
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic [7:0]              io_data,
    input  logic                    pix_bit,
    input  logic [7:0]              attr,
    input  logic                    flash_phase,
    input  logic [NPL-1:0]          planes,
    input  logic [COL_W-1:0]        border,
    output logic [COL_W-1:0]        colour,
    output logic [NREG*REG_W-1:0]   ctrl_regs
);
    logic [REG_W-1:0] method;
    logic [COL_W-1:0] colour_d;

    ctrl_regfile #(
        .ADDR_W(ADDR_W), .PORT_ADR(PORT_ADR), .IDX_W(4), .VAL_W(REG_W),
        .SEL_IDX(SEL_IDX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(io_wr), .addr(io_addr), .data(io_data),
        .regs_flat(ctrl_regs), .sel_val(method)
    );

    attr_decode_core #(.COL_W(COL_W), .CLR_W(3), .NPL(NPL)) u_core (
        .method(method), .pix_bit(pix_bit), .attr(attr),
        .flash_phase(flash_phase), .planes(planes), .border(border),
        .colour(colour_d)
    );

    // Output register holding the decoded colour.
    always_ff @(posedge clk) begin
        if (!rst_n) colour <= '0;
        else        colour <= colour_d;
    end

    // R1: reset clears the output.
    a_r1_colour_clear: assert property (@(posedge clk)
        !rst_n |=> colour == '0);

    // R7: the 32-colour decode stays within 0..31.
    a_r7_range32: assert property (@(posedge clk) disable iff (!rst_n)
        method == M_BRIGHT4 |=> colour < COL_W'(32));

    // R9: the planar decode follows the plane bits only.
    a_r9_planar: assert property (@(posedge clk) disable iff (!rst_n)
        method == M_PLANAR |=> colour == COL_W'($past(planes)));

    // R8: the 256-colour paper pixels take the border.
    a_r8_paper_border: assert property (@(posedge clk) disable iff (!rst_n)
        (method == M_FULL8 && !pix_bit) |=> colour == $past(border));
endmodule

// File: tb/attr_colour_decoder_test.sv
module attr_colour_decoder_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        io_wr = 0;
    logic [15:0] io_addr = 0;
    logic [7:0]  io_data = 0;
    logic        pix_bit = 0;
    logic [7:0]  attr = 0;
    logic        flash_phase = 0;
    logic [3:0]  planes = 0;
    logic [7:0]  border = 0;
    logic [7:0]  colour;
    logic [63:0] ctrl_regs;

    int checks = 0;
    int errors = 0;
    logic [3:0] m_regs [16];

    always #5 clk = ~clk;

    attr_colour_decoder uut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_data(io_data), .pix_bit(pix_bit), .attr(attr),
        .flash_phase(flash_phase), .planes(planes), .border(border),
        .colour(colour), .ctrl_regs(ctrl_regs)
    );

    function automatic logic [7:0] model(input logic [3:0] m, input logic p,
        input logic [7:0] a, input logic f, input logic [3:0] pl,
        input logic [7:0] bd);
        logic s;
        case (m)
            4'b0001: return p ? {4'b0, a[6], a[2:0]} : {4'b0, a[7], a[5:3]};
            4'b0010: return {3'b0, a[7], a[6], (p ? a[2:0] : a[5:3])};
            4'b0100: return p ? a : bd;
            4'b0110: return {4'b0, pl};
            default: begin
                s = p ^ (a[7] & f);
                return {4'b0, a[6], (s ? a[2:0] : a[5:3])};
            end
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] m, input logic [7:0] a,
                                     input logic f);
        case (m)
            4'b0000: return (a[7] && f) ? "R5" : "R4";
            4'b0001: return "R6";
            4'b0010: return "R7";
            4'b0100: return "R8";
            4'b0110: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1; io_addr = a; io_data = d;
        @(posedge clk);
        if (a == 16'h8E3B) m_regs[d[7:4]] = d[3:0];
        @(negedge clk);
        io_wr = 0;
    endtask

    task automatic pixel(input logic p, input logic [7:0] a, input logic f,
                         input logic [3:0] pl, input logic [7:0] bd,
                         input string tag);
        logic [7:0] e;
        @(negedge clk);
        pix_bit = p; attr = a; flash_phase = f; planes = pl; border = bd;
        e = model(m_regs[3], p, a, f, pl, bd);
        @(posedge clk); #1;
        check(tag, colour, e);
    endtask

    function automatic logic [63:0] flat_model();
        logic [63:0] r;
        for (int i = 0; i < 16; i++) r[i*4 +: 4] = m_regs[i];
        return r;
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) m_regs[i] = 0;
        // Load the registers and pixel inputs with junk during reset.
        io_wr = 1; io_addr = 16'h8E3B; io_data = 8'h36; attr = 8'hFF; pix_bit = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        io_wr = 0; #1;
        check("R1 colour", colour, 0);
        check("R1 regs", ctrl_regs, 0);
        rst_n = 1;

        // R1: the default method is the standard decode.
        pixel(1, 8'b0101_0011, 0, 4'hF, 8'hAA, "R1 default method");
        pixel(0, 8'b0101_0011, 0, 4'hF, 8'hAA, "R4 paper");

        // R2: a matching write loads register 3, and the bus shows it.
        wr_reg(16'h8E3B, 8'h36);
        check("R2 reg3", ctrl_regs, flat_model());
        pixel(0, 8'h12, 0, 4'b1010, 8'h00, "R9 planar");
        pixel(1, 8'hFF, 1, 4'b0001, 8'h77, "R9 attr ignored");

        // R3: writes elsewhere do not move the method or any register.
        wr_reg(16'h8E3A, 8'h30);
        wr_reg(16'h0E3B, 8'h30);
        wr_reg(16'h8E3B, 8'h52);
        check("R3 regs", ctrl_regs, flat_model());
        @(negedge clk);
        io_addr = 16'h8E3B; io_data = 8'h30; io_wr = 0;
        @(posedge clk); #1;
        check("R3 no strobe", ctrl_regs, flat_model());
        pixel(0, 8'h00, 0, 4'b0110, 8'h00, "R3 method kept");

        // R5: the flash swap applies only in the standard decode.
        wr_reg(16'h8E3B, 8'h30);
        pixel(1, 8'b1000_1101, 1, 0, 0, "R5 swap ink");
        pixel(0, 8'b1100_1101, 1, 0, 0, "R5 swap paper");
        pixel(1, 8'b1000_1101, 0, 0, 0, "R5 phase low");
        wr_reg(16'h8E3B, 8'h31);
        pixel(1, 8'b1000_1101, 1, 0, 0, "R6 no flash");
        pixel(0, 8'b1000_1101, 1, 0, 0, "R6 paper bright");

        // R7: the top brightness level reaches 31.
        wr_reg(16'h8E3B, 8'h32);
        pixel(1, 8'hC7, 0, 0, 0, "R7 max");
        // R8: the whole byte on ink, the border on paper.
        wr_reg(16'h8E3B, 8'h34);
        pixel(1, 8'hE9, 1, 0, 8'h5C, "R8 ink byte");
        pixel(0, 8'hE9, 1, 0, 8'h5C, "R8 border");
        // R10: a reserved code falls back to the standard decode, flash included.
        wr_reg(16'h8E3B, 8'h3B);
        pixel(1, 8'b1100_0010, 1, 0, 0, "R10 reserved");

        // R11: the output holds between edges and follows the previous edge.
        wr_reg(16'h8E3B, 8'h34);
        pixel(1, 8'h9A, 0, 0, 8'h11, "R11 first");
        @(negedge clk);
        attr = 8'h3C; #1;
        check("R11 hold", colour, 8'h9A);
        @(posedge clk); #1;
        check("R11 next", colour, 8'h3C);

        // Random mix of control writes and pixels.
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r == 0) begin
                logic [15:0] a;
                logic [7:0]  d;
                a = ($urandom_range(0, 2) != 0) ? 16'h8E3B : 16'($urandom);
                d = 8'($urandom);
                if ($urandom_range(0, 1) == 1) d[7:4] = 4'd3;
                wr_reg(a, d);
                check("R2 R3 regs", ctrl_regs, flat_model());
            end else begin
                logic [7:0] a;
                logic       f;
                a = 8'($urandom);
                f = 1'($urandom);
                pixel(1'($urandom), a, f, 4'($urandom), 8'($urandom),
                      tag_of(m_regs[3], a, f));
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule